// File: doc/BRIEF.md
# Log-Domain Soft Survivor Update Element

This block is a single processing element of the survivor-update column in a forward-only soft-output trellis detector. Each such element owns one soft survivor, identified by a trellis state and an input label, at one position of the sliding window. On every valid cycle it reads the survivors held by the previous window position, for the same input label, at the two predecessor states. It also reads the branch metric on each of the two connecting branches. From these it forms the survivor for its own position.

All arithmetic is in the log domain, so the sum of path probabilities becomes a max-star operation. Each candidate is a survivor plus its branch metric. The larger candidate is kept, and a small correction term is added to it. The correction comes from a table indexed by how far apart the two candidates are. The result is then normalised: a column-wide offset, supplied from outside, is subtracted from it, and the difference is clamped to the survivor range.

The work is split over two register stages. The first stage does the adds, the compare and the select. The second does the table look-up, the correction add and the normalisation. A valid flag travels alongside the data. The input label needs no logic here, because the array routes survivors of one label only. Many of these elements, one per state and label pair and window position, are tiled by the surrounding array.

Top module: `logmap_surv_update`

## Requirements
- R1: While `rst_n` is low, `out_vld` and `out_surv` are both 0.
- R2: Each predecessor contributes a candidate equal to its 7-bit unsigned survivor plus its 6-bit unsigned branch metric, computed without wrap (range 0 to 190). The larger of the two candidates is selected.
- R3: A correction is added to the selected candidate. It is looked up by the absolute candidate difference, clamped to 7. The table gives 2 for a difference of 0, 1 for a difference of 1 or 2, and 0 for a difference of 3 or more.
- R4: The 8-bit unsigned `col_offset`, sampled together with the inputs of the same update, is subtracted from the corrected value. A negative result gives `out_surv` = 0.
- R5: A result above 127 gives `out_surv` = 127.
- R6: An update presented with `in_vld` high before clock edge N appears on `out_surv`, with `out_vld` high, after edge N+1. `out_vld` is low after edge N+1 when `in_vld` was low before edge N. Back-to-back updates stream at one per cycle.
- R7: Inputs presented with `in_vld` low are ignored: `out_surv` keeps its last value.
- R8: Exchanging the two predecessors, that is swapping the survivor and branch metric pairs, gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Inputs of this cycle form an update |
| surv_a | input | 7 | Previous-column survivor, first predecessor |
| surv_b | input | 7 | Previous-column survivor, second predecessor |
| bm_a | input | 6 | Branch metric, first predecessor to this state |
| bm_b | input | 6 | Branch metric, second predecessor to this state |
| col_offset | input | 8 | Normalisation offset for this update |
| out_vld | output | 1 | `out_surv` holds a new update |
| out_surv | output | 7 | Updated normalised survivor |

## Verification
The streamed vectors are chosen so that each correction band, differences 0, 1, 2, 3 and a clamped large gap, is used at least once. A wrong table entry or a wrong band edge therefore shows up as an off-by-one or off-by-two result. Further vectors push the corrected value below the offset and above 127, and one pair of vectors differs only in predecessor order. These separate errors in the clamps from errors in the selection. Single isolated pulses, and idle cycles carrying changing inputs, expose any latency other than two cycles and any capture of inputs that are not valid.

// File: rtl/lmsu_pkg.sv
package lmsu_pkg;
  // Binary trellis: every state has two predecessors.
  localparam int NPRED = 2;
  // Default field widths of the update element.
  localparam int SURV_W = 7;
  localparam int BM_W   = 6;
  localparam int IDX_W  = 3;
  localparam int CORR_W = 2;
endpackage

// File: rtl/lmsu_acs_stage.sv
module lmsu_acs_stage #(
  parameter int SW   = 7,
  parameter int BW   = 6,
  parameter int IDXW = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_vld,
  input  logic [SW-1:0]                surv_a,
  input  logic [SW-1:0]                surv_b,
  input  logic [BW-1:0]                bm_a,
  input  logic [BW-1:0]                bm_b,
  input  logic [((SW > BW) ? SW : BW):0] col_off,
  output logic                         s1_vld,
  output logic [((SW > BW) ? SW : BW):0] s1_max,
  output logic [IDXW-1:0]              s1_idx,
  output logic [((SW > BW) ? SW : BW):0] s1_off
);
  localparam int SUMW = ((SW > BW) ? SW : BW) + 1;
  localparam logic [IDXW-1:0] IDX_MAX = '1;

  logic [SUMW-1:0] cand_a, cand_b, diff_w, max_d;
  logic [IDXW-1:0] idx_d;
  logic            a_wins;

  // add, compare, select
  always_comb begin
    cand_a = SUMW'(surv_a) + SUMW'(bm_a);
    cand_b = SUMW'(surv_b) + SUMW'(bm_b);
    a_wins = (cand_a >= cand_b);
    max_d  = a_wins ? cand_a : cand_b;
    diff_w = a_wins ? (cand_a - cand_b) : (cand_b - cand_a);
    if (diff_w > SUMW'(IDX_MAX)) idx_d = IDX_MAX;
    else                         idx_d = diff_w[IDXW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      s1_max <= '0;
      s1_idx <= '0;
      s1_off <= '0;
    end else begin
      s1_vld <= in_vld;
      if (in_vld) begin
        s1_max <= max_d;
        s1_idx <= idx_d;
        s1_off <= col_off;
      end
    end
  end

  // R2: the captured maximum dominates both candidates of that cycle
  p_sel_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> (s1_max >= $past(cand_a)) && (s1_max >= $past(cand_b)));

  // R7: non-valid inputs leave the first stage untouched
  p_s1_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(s1_max) && $stable(s1_off));
endmodule

// File: rtl/lmsu_corr_lut.sv
module lmsu_corr_lut #(
  parameter int IDXW = 3,
  parameter int CW   = 2
) (
  input  logic [IDXW-1:0] idx,
  output logic [CW-1:0]   corr
);
  // Rounded log(1 + exp(-d)) in units where the metric step is about 0.5.
  localparam logic [IDXW-1:0] BAND1_END = IDXW'(2);

  always_comb begin
    if (idx == '0)             corr = CW'(2);
    else if (idx <= BAND1_END) corr = CW'(1);
    else                       corr = '0;
  end
endmodule

// File: rtl/lmsu_norm_stage.sv
module lmsu_norm_stage #(
  parameter int SW   = 7,
  parameter int SUMW = 8,
  parameter int IDXW = 3,
  parameter int CW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            s1_vld,
  input  logic [SUMW-1:0] s1_max,
  input  logic [IDXW-1:0] s1_idx,
  input  logic [SUMW-1:0] s1_off,
  output logic            out_vld,
  output logic [SW-1:0]   out_surv
);
  localparam int RESW = SUMW + 1;
  localparam logic [SW-1:0] SURV_MAX = '1;

  logic [CW-1:0]   corr;
  logic [RESW-1:0] sum_w;
  logic [RESW:0]   diff_w;
  logic [SW-1:0]   surv_d;

  lmsu_corr_lut #(.IDXW(IDXW), .CW(CW)) i_lut (
    .idx  (s1_idx),
    .corr (corr)
  );

  // correction add, offset subtract, clamp
  always_comb begin
    sum_w  = RESW'(s1_max) + RESW'(corr);
    diff_w = {1'b0, sum_w} - (RESW+1)'(s1_off);
    if (diff_w[RESW])                               surv_d = '0;
    else if (diff_w[RESW-1:0] > RESW'(SURV_MAX))    surv_d = SURV_MAX;
    else                                            surv_d = diff_w[SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_surv <= '0;
    end else begin
      out_vld <= s1_vld;
      if (s1_vld) out_surv <= surv_d;
    end
  end

  // R4: a maximum below the offset can only clamp to zero
  p_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && (RESW'(s1_max) + RESW'(3) < RESW'(s1_off))) |=> (out_surv == '0));

  // R5: a maximum at least offset plus full range clamps to the top
  p_ceil_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && (RESW'(s1_max) >= RESW'(s1_off) + RESW'(SURV_MAX))) |=> (out_surv == SURV_MAX));

  // R7: output holds when no update reaches it
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(out_surv));
endmodule

// File: rtl/logmap_surv_update.sv
module logmap_surv_update
  import lmsu_pkg::*;
#(
  parameter int SW   = SURV_W,
  parameter int BW   = BM_W,
  parameter int IDXW = IDX_W,
  parameter int CW   = CORR_W
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             in_vld,
  input  logic [SW-1:0]                    surv_a,
  input  logic [SW-1:0]                    surv_b,
  input  logic [BW-1:0]                    bm_a,
  input  logic [BW-1:0]                    bm_b,
  input  logic [((SW > BW) ? SW : BW):0]   col_offset,
  output logic                             out_vld,
  output logic [SW-1:0]                    out_surv
);
  localparam int SUMW = ((SW > BW) ? SW : BW) + 1;

  logic            s1_vld;
  logic [SUMW-1:0] s1_max, s1_off;
  logic [IDXW-1:0] s1_idx;

  lmsu_acs_stage #(.SW(SW), .BW(BW), .IDXW(IDXW)) i_acs (
    .clk    (clk),
    .rst_n  (rst_n),
    .in_vld (in_vld),
    .surv_a (surv_a),
    .surv_b (surv_b),
    .bm_a   (bm_a),
    .bm_b   (bm_b),
    .col_off(col_offset),
    .s1_vld (s1_vld),
    .s1_max (s1_max),
    .s1_idx (s1_idx),
    .s1_off (s1_off)
  );

  lmsu_norm_stage #(.SW(SW), .SUMW(SUMW), .IDXW(IDXW), .CW(CW)) i_norm (
    .clk     (clk),
    .rst_n   (rst_n),
    .s1_vld  (s1_vld),
    .s1_max  (s1_max),
    .s1_idx  (s1_idx),
    .s1_off  (s1_off),
    .out_vld (out_vld),
    .out_surv(out_surv)
  );

  // R6: a valid update emerges exactly two edges later
  p_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld);

  // R6: no valid output without a valid input two edges earlier
  p_novld_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ##1 !out_vld);
endmodule

// File: tb/test_logmap_surv_update.sv
module test_logmap_surv_update;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  typedef struct packed {
    logic [6:0] sa;
    logic [5:0] ba;
    logic [6:0] sb;
    logic [5:0] bb;
    logic [7:0] off;
    logic [6:0] exp_v;
  } vec_t;

  // {surv_a, bm_a, surv_b, bm_b, col_offset, expected}
  localparam vec_t VEC [NVEC] = '{
    '{7'd10,  6'd5,  7'd20,  6'd3,  8'd0,  7'd23},  // R2 b wins, gap 8 -> corr 0
    '{7'd30,  6'd2,  7'd10,  6'd20, 8'd0,  7'd33},  // R3 gap 2 -> corr 1
    '{7'd40,  6'd10, 7'd45,  6'd5,  8'd4,  7'd48},  // R3 tie -> corr 2, R4 offset
    '{7'd12,  6'd3,  7'd10,  6'd4,  8'd0,  7'd16},  // R3 gap 1 -> corr 1
    '{7'd100, 6'd50, 7'd90,  6'd40, 8'd10, 7'd127}, // R5 clamp high
    '{7'd5,   6'd1,  7'd3,   6'd2,  8'd20, 7'd0},   // R4 clamp low
    '{7'd127, 6'd63, 7'd127, 6'd63, 8'd0,  7'd127}, // R5 largest operands
    '{7'd60,  6'd0,  7'd0,   6'd57, 8'd50, 7'd10},  // R3 gap 3 -> corr 0
    '{7'd0,   6'd0,  7'd0,   6'd0,  8'd0,  7'd2},   // R3 all zero tie
    '{7'd20,  6'd5,  7'd70,  6'd0,  8'd48, 7'd22},  // R4 large gap, offset
    '{7'd64,  6'd0,  7'd62,  6'd0,  8'd66, 7'd0},   // R4 one below zero
    '{7'd63,  6'd63, 7'd0,   6'd0,  8'd1,  7'd125}, // R2 a wins by far
    '{7'd10,  6'd20, 7'd30,  6'd2,  8'd0,  7'd33}   // R8 swap of entry 1
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_vld;
  logic [6:0] surv_a, surv_b;
  logic [5:0] bm_a, bm_b;
  logic [7:0] col_offset;
  logic       out_vld;
  logic [6:0] out_surv;

  int n_chk = 0;
  int n_bad = 0;
  logic [6:0] last_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  logmap_surv_update i_logmap_surv_update (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld),
    .surv_a(surv_a), .surv_b(surv_b), .bm_a(bm_a), .bm_b(bm_b),
    .col_offset(col_offset), .out_vld(out_vld), .out_surv(out_surv)
  );

  task automatic chk(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    surv_a = v.sa; bm_a = v.ba; surv_b = v.sb; bm_b = v.bb;
    col_offset = v.off; in_vld = vld;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(VEC[4], 1'b1);
    repeat (3) @(negedge clk);
    chk("R1 reset out_vld", int'(out_vld), 0);
    chk("R1 reset out_surv", int'(out_surv), 0);
    rst_n = 1'b1;
    in_vld = 1'b0;
    @(negedge clk);

    // streamed vectors, one per cycle; result of vector i read two negedges later
    for (int i = 0; i < NVEC + 2; i++) begin
      if (i >= 2) begin
        chk($sformatf("R6 vec %0d out_vld", i-2), int'(out_vld), 1);
        chk($sformatf("R2 R3 R4 R5 R8 vec %0d value", i-2), int'(out_surv), int'(VEC[i-2].exp_v));
      end
      if (i < NVEC) drive(VEC[i], 1'b1);
      else          in_vld = 1'b0;
      @(negedge clk);
    end

    // isolated pulse: latency of exactly two edges
    drive(VEC[1], 1'b1);
    @(negedge clk);
    in_vld = 1'b0;
    chk("R6 pulse not early", int'(out_vld), 0);
    @(negedge clk);
    chk("R6 pulse valid", int'(out_vld), 1);
    chk("R6 pulse value", int'(out_surv), 33);
    last_v = out_surv;
    @(negedge clk);
    chk("R6 pulse drop", int'(out_vld), 0);

    // idle cycles with changing inputs: ignored
    for (int k = 0; k < 4; k++) begin
      drive(VEC[(k * 3) % NVEC], 1'b0);
      @(negedge clk);
      chk("R7 idle out_vld", int'(out_vld), 0);
      chk("R7 idle hold", int'(out_surv), int'(last_v));
    end

    // reset in mid operation
    drive(VEC[6], 1'b1);
    @(negedge clk);
    @(negedge clk);
    chk("R5 pre-reset value", int'(out_surv), 127);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset out_vld", int'(out_vld), 0);
    chk("R1 async reset out_surv", int'(out_surv), 0);
    in_vld = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule